// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command into the stream of column addresses that an SDRAM read or write burst visits. A command carries a starting column, a length code, a wrap order, a read/write flag and the device organisation. After each rising edge the block presents one column address together with a flag that marks the final beat of the burst.

Both wrap orders keep the burst inside a block that is aligned to its length. A full-page burst walks the whole column space and never stops by itself. A separate terminate input ends any burst early. A new command may arrive on any clock, and it replaces whatever burst is running. An optional mode shortens every write burst to one beat and leaves reads at their programmed length.

The block sits between a command decoder and the column address pins. It does not handle CAS latency or the data path.

Top module: `sdr_burst_colgen`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `col_valid`, `col_last` and `col_addr` are all 0. Whenever `col_valid` is 0, `col_addr` is 0 and `col_last` is 0.
- R2: A cycle with `cmd_valid` high makes `col_valid` 1 after that edge. The first address is `start_col` with every bit above the active column width cleared.
- R3: `bl_sel` selects the burst length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives a full page. The unused codes give 1 beat. A fixed burst that is not interrupted keeps `col_valid` high for exactly that many cycles. `col_last` is high only on the final one.
- R4: With `wrap_il`=0, each beat of a fixed burst of length N adds one, modulo N, to the low log2(N) bits of the address. The bits above them keep the start column's value.
- R5: With `wrap_il`=1, beat k of a fixed burst of length N has low log2(N) bits equal to the start's low bits XOR k. The bits above them stay fixed.
- R6: In a full-page burst the address goes up by one per beat. It wraps to 0 after the top column of the active width and continues until it is terminated or replaced. `col_last` is never asserted, and `wrap_il` has no effect.
- R7: When `wr_single`=1, a command with `cmd_write`=1 gives a single beat whatever `bl_sel` holds. A command with `cmd_write`=0 keeps its programmed length.
- R8: `org` sets the column width: 2'b00 gives 10 bits, 2'b01 gives 9 bits, and 2'b10 or 2'b11 give 8 bits. Every address bit above that width is 0.
- R9: A command that arrives during a burst restarts the sequence from the new start on the next cycle. When `cmd_valid` and `term` are high together, the command takes priority.
- R10: `term` high with `cmd_valid` low makes `col_valid` 0 after that edge, for fixed and full-page bursts alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Column command present this cycle |
| cmd_write | input | 1 | The command is a write |
| start_col | input | 10 | Starting column of the burst |
| bl_sel | input | 3 | Burst length code |
| wrap_il | input | 1 | 0 = sequential order, 1 = interleaved order |
| wr_single | input | 1 | Force write bursts to one beat |
| org | input | 2 | Device organisation, which sets the column width |
| term | input | 1 | End the current burst |
| col_valid | output | 1 | `col_addr` holds a burst address |
| col_addr | output | 10 | Column address for this beat |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
The assertions check on every cycle the rules that need only the cycle just past:
- consecutive beats of a burst keep the same bits above the wrap block;
- sequential beats step by one inside the block;
- no address bit lies outside the column width;
- a command, a terminate, a last beat and a single-beat write each produce the correct next `col_valid` or `col_last`.

Only the bench scenarios show the whole address order of an interleaved burst, the exact beat count for each length code, the wrap point of a full page at each width, and the restart address after an interruption. Each of these depends on the full sequence and not on one step of it.

// File: rtl/sdr_colgen_pkg.sv
package sdr_colgen_pkg;

    typedef enum logic [2:0] {
        BLC_ONE   = 3'b000,
        BLC_TWO   = 3'b001,
        BLC_FOUR  = 3'b010,
        BLC_EIGHT = 3'b011,
        BLC_PAGE  = 3'b111
    } bl_code_e;

    typedef enum logic [1:0] {
        ORG_WIDE   = 2'b00,
        ORG_MID    = 2'b01,
        ORG_NARROW = 2'b10
    } org_code_e;

endpackage

// File: rtl/sdr_burst_len_dec.sv
module sdr_burst_len_dec
    import sdr_colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [2:0]       bl_code,
    input  logic             is_write,
    input  logic             wr_single,
    output logic [COL_W-1:0] len_m1,
    output logic             full_page
);
    always_comb begin
        len_m1    = '0;
        full_page = 1'b0;
        if (!(is_write && wr_single)) begin
            case (bl_code)
                BLC_ONE:   len_m1 = COL_W'(0);
                BLC_TWO:   len_m1 = COL_W'(1);
                BLC_FOUR:  len_m1 = COL_W'(3);
                BLC_EIGHT: len_m1 = COL_W'(7);
                BLC_PAGE:  full_page = 1'b1;
                default:   len_m1 = COL_W'(0);
            endcase
        end
    end
endmodule

// File: rtl/sdr_col_width_dec.sv
module sdr_col_width_dec #(
    parameter int COL_W   = 10,
    parameter int NUM_ORG = 3,
    parameter int ORG_W   = 2
) (
    input  logic [ORG_W-1:0] org,
    output logic [COL_W-1:0] col_mask
);
    logic [COL_W-1:0] mask_tbl [NUM_ORG];

    // Each organisation step drops one column bit.
    for (genvar g = 0; g < NUM_ORG; g++) begin : g_mask
        assign mask_tbl[g] = COL_W'((64'd1 << (COL_W - g)) - 64'd1);
    end

    always_comb begin
        col_mask = mask_tbl[NUM_ORG-1];
        for (int i = 0; i < NUM_ORG; i++) begin
            if (int'(org) == i) col_mask = mask_tbl[i];
        end
    end
endmodule

// File: rtl/sdr_col_addr_calc.sv
module sdr_col_addr_calc #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] blk_mask,
    input  logic             il_mode,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] seq_val;
    logic [COL_W-1:0] il_val;

    assign seq_val = base + beat;
    assign il_val  = base ^ beat;

    // Bits inside the wrap block move; bits above it keep the base value.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign addr[b] = blk_mask[b] ? (il_mode ? il_val[b] : seq_val[b]) : base[b];
    end
endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
    import sdr_colgen_pkg::*;
#(
    parameter int COL_W   = 10,
    parameter int ORG_W   = 2,
    parameter int NUM_ORG = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       bl_sel,
    input  logic             wrap_il,
    input  logic             wr_single,
    input  logic [ORG_W-1:0] org,
    input  logic             term,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             col_last
);
    typedef struct packed {
        logic             active;
        logic             valid;
        logic             last;
        logic             full;
        logic             il;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] cnt;
        logic [COL_W-1:0] len_m1;
        logic [COL_W-1:0] blk_mask;
        logic [COL_W-1:0] col_mask;
        logic [COL_W-1:0] addr;
    } gen_st_t;

    gen_st_t st_d, st_q;

    logic [COL_W-1:0] dec_len_m1;
    logic             dec_full;
    logic [COL_W-1:0] dec_col_mask;
    logic [COL_W-1:0] calc_base, calc_beat, calc_mask, calc_addr;
    logic             calc_il;

    sdr_burst_len_dec #(.COL_W(COL_W)) u_len (
        .bl_code   (bl_sel),
        .is_write  (cmd_write),
        .wr_single (wr_single),
        .len_m1    (dec_len_m1),
        .full_page (dec_full)
    );

    sdr_col_width_dec #(.COL_W(COL_W), .NUM_ORG(NUM_ORG), .ORG_W(ORG_W)) u_width (
        .org      (org),
        .col_mask (dec_col_mask)
    );

    sdr_col_addr_calc #(.COL_W(COL_W)) u_calc (
        .base     (calc_base),
        .beat     (calc_beat),
        .blk_mask (calc_mask),
        .il_mode  (calc_il),
        .addr     (calc_addr)
    );

    always_comb begin
        if (cmd_valid) begin
            calc_base = start_col & dec_col_mask;
            calc_beat = '0;
            calc_mask = dec_full ? dec_col_mask : dec_len_m1;
            calc_il   = wrap_il && !dec_full;
        end else begin
            calc_base = st_q.start;
            calc_beat = st_q.cnt + COL_W'(1);
            calc_mask = st_q.blk_mask;
            calc_il   = st_q.il;
        end
    end

    always_comb begin
        st_d = st_q;
        if (cmd_valid) begin
            st_d.start    = calc_base;
            st_d.cnt      = '0;
            st_d.len_m1   = dec_len_m1;
            st_d.full     = dec_full;
            st_d.il       = calc_il;
            st_d.blk_mask = calc_mask;
            st_d.col_mask = dec_col_mask;
            st_d.valid    = 1'b1;
            st_d.addr     = calc_addr;
            st_d.last     = !dec_full && (dec_len_m1 == '0);
            st_d.active   = !st_d.last;
        end else if (term || !st_q.active) begin
            st_d.active = 1'b0;
            st_d.valid  = 1'b0;
            st_d.last   = 1'b0;
            st_d.addr   = '0;
        end else begin
            st_d.cnt    = calc_beat;
            st_d.valid  = 1'b1;
            st_d.addr   = calc_addr;
            st_d.last   = !st_q.full && (calc_beat == st_q.len_m1);
            st_d.active = !st_d.last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign col_valid = st_q.valid;
    assign col_addr  = st_q.addr;
    assign col_last  = st_q.last;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !col_valid |-> (col_addr == '0) && !col_last);

    p_cmd_starts_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> col_valid);

    p_last_ends_r3: assert property (@(posedge clk) disable iff (rst)
        col_last && !cmd_valid |=> !col_valid);

    p_upper_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        col_valid && $past(col_valid) && !$past(cmd_valid)
        |-> ((col_addr ^ $past(col_addr)) & ~st_q.blk_mask) == '0);

    p_seq_step_r4: assert property (@(posedge clk) disable iff (rst)
        col_valid && $past(col_valid) && !$past(cmd_valid) && !st_q.il
        |-> ((col_addr - $past(col_addr)) & st_q.blk_mask) == COL_W'(1));

    p_page_no_last_r6: assert property (@(posedge clk) disable iff (rst)
        col_valid && st_q.full |-> !col_last);

    p_write_single_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_write && wr_single |=> col_last);

    p_width_r8: assert property (@(posedge clk) disable iff (rst)
        col_valid |-> (col_addr & ~st_q.col_mask) == '0);

    p_term_stops_r10: assert property (@(posedge clk) disable iff (rst)
        term && !cmd_valid |=> !col_valid);

endmodule

// File: tb/tb_sdr_burst_colgen.sv
module tb_sdr_burst_colgen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0, cmd_write = 1'b0, wrap_il = 1'b0, wr_single = 1'b0, term = 1'b0;
    logic [9:0] start_col = '0;
    logic [2:0] bl_sel = '0;
    logic [1:0] org = '0;
    logic       col_valid, col_last;
    logic [9:0] col_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    sdr_burst_colgen dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .start_col(start_col), .bl_sel(bl_sel), .wrap_il(wrap_il),
        .wr_single(wr_single), .org(org), .term(term),
        .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last)
    );

    typedef struct {
        logic       v;
        logic [9:0] a;
        logic       l;
        string      tag;
    } exp_t;

    exp_t q[$];

    // Reference state built from the requirements.
    int ms = 0, mc = 0, mlen = 1, mcm = 1023;
    bit mfull = 0, mil = 0, mact = 0;

    function automatic int model_addr();
        int bm, low;
        bm  = mfull ? mcm : (mlen - 1);
        if (mfull || !mil) low = (ms + mc) & bm;   // R4, R6
        else               low = (ms ^ mc) & bm;   // R5
        return (ms & ~bm) | low;
    endfunction

    task automatic step(input bit cv, input bit wr, input int start, input int bl,
                        input bit il, input bit ws, input int og, input bit tm,
                        input string tag);
        exp_t e;
        int w;
        @(negedge clk);
        cmd_valid = cv; cmd_write = wr; start_col = 10'(start); bl_sel = 3'(bl);
        wrap_il = il; wr_single = ws; org = 2'(og); term = tm;
        e.tag = tag;
        if (cv) begin
            w   = (og == 0) ? 10 : (og == 1) ? 9 : 8;   // R8
            mcm = (1 << w) - 1;
            ms  = start & mcm;
            mc  = 0;
            mil = il;
            mfull = 0;
            if (wr && ws) mlen = 1;                     // R7
            else case (bl)
                0: mlen = 1;
                1: mlen = 2;
                2: mlen = 4;
                3: mlen = 8;
                7: begin mfull = 1; mlen = 0; end
                default: mlen = 1;                      // R3
            endcase
            e.v = 1; e.a = 10'(model_addr()); e.l = !mfull && mlen == 1;
            mact = !e.l;
        end else if (tm || !mact) begin
            mact = 0;
            e.v = 0; e.a = '0; e.l = 0;
        end else begin
            mc = mc + 1;
            e.v = 1; e.a = 10'(model_addr()); e.l = !mfull && (mc == mlen - 1);
            mact = !e.l;
        end
        q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // Monitor: one expectation per cycle, sampled just after the edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                total++;
                if (col_valid !== e.v || col_addr !== e.a || col_last !== e.l) begin
                    bad++;
                    $display("FAIL %s: got v=%0b a=%h l=%0b, expected v=%0b a=%h l=%0b",
                             e.tag, col_valid, col_addr, col_last, e.v, e.a, e.l);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got running, expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        total++;   // R1 reset state
        if (col_valid !== 1'b0 || col_addr !== '0 || col_last !== 1'b0) begin
            bad++;
            $display("FAIL R1: got v=%0b a=%h l=%0b, expected v=0 a=000 l=0",
                     col_valid, col_addr, col_last);
        end
        @(negedge clk); rst = 1'b0;
        idle(2, "R1");

        // R4 sequential 8-beat, start low bits 5, upper part kept
        step(1, 0, 'h3D5, 3, 0, 0, 0, 0, "R4");
        idle(9, "R4");
        // R5 interleaved 8-beat from low bits 6
        step(1, 0, 'h0A6, 3, 1, 0, 0, 0, "R5");
        idle(9, "R5");
        // R3 lengths 4, 2 (interleaved), 1 and a reserved code
        step(1, 0, 'h10E, 2, 0, 0, 0, 0, "R3");
        idle(5, "R3");
        step(1, 0, 'h011, 1, 1, 0, 0, 0, "R3");
        idle(3, "R3");
        step(1, 0, 'h222, 0, 0, 0, 0, 0, "R3");
        idle(2, "R3");
        step(1, 0, 'h155, 5, 0, 0, 0, 0, "R3");
        idle(2, "R3");
        // R7 single write, read unaffected, write without the option
        step(1, 1, 'h047, 3, 0, 1, 0, 0, "R7");
        idle(2, "R7");
        step(1, 0, 'h047, 3, 0, 1, 0, 0, "R7");
        idle(9, "R7");
        step(1, 1, 'h047, 2, 1, 0, 0, 0, "R7");
        idle(5, "R7");
        // R6 full page at 9-bit width, wraps past 0x1FF, interleave ignored; R10 ends it
        step(1, 0, 'h3FD, 7, 1, 0, 1, 0, "R6");
        idle(6, "R6");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R10");
        idle(3, "R10");
        // R8 8-bit width masking and full page wrap at 0xFF
        step(1, 0, 'h3FE, 7, 0, 0, 2, 0, "R8");
        idle(4, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R8");
        step(1, 0, 'h3FF, 2, 0, 0, 3, 0, "R8");
        idle(5, "R8");
        // R9 restart mid burst, then command together with term
        step(1, 0, 'h100, 3, 0, 0, 0, 0, "R9");
        idle(3, "R9");
        step(1, 0, 'h20B, 2, 1, 0, 0, 0, "R9");
        idle(1, "R9");
        step(1, 0, 'h0F3, 3, 0, 0, 0, 1, "R9");
        idle(9, "R9");
        // R10 term inside a fixed burst
        step(1, 0, 'h062, 3, 1, 0, 0, 0, "R10");
        idle(2, "R10");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R10");
        idle(3, "R10");
        // R2 back-to-back commands on consecutive cycles
        step(1, 0, 'h3C3, 3, 0, 0, 0, 0, "R2");
        step(1, 0, 'h1E9, 1, 0, 0, 1, 0, "R2");
        idle(4, "R2");

        @(negedge clk);
        while (q.size() > 0) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule